// File: doc/BRIEF.md
# BCD Calendar Countdown Chain

This block keeps wall-clock time and calendar date as a chain of packed BCD counters: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. A prescaler divides the 32.768 kHz oscillator clock down to one enable pulse per second. Each counter advances on that pulse, and each one carries into the next when it wraps. The last day of each month comes from the month and the year, with the leap-year rule applied in hardware.

Software sets the time by presenting all seven fields and pulsing a load strobe. The same strobe restarts the prescaler, so the first second after a load is a full second long. The oscillator enable gates the prescaler. It is low after reset, so nothing counts until software raises it. All fields are driven out continuously, and a buffered register window samples them from there.

Top module: `rtc_calendar_chain`

## Requirements
- R1: After reset the time reads 00:00:00, the date reads year 00, month 01, day 01, day of week 1, and `sec_tick` is low.
- R2: While `osc_en` is low and `load` is low, no field changes and `sec_tick` stays low.
- R3: With `osc_en` held high, `sec_tick` pulses for one cycle once every 2^PRESC_BITS cycles. The fields change only on the edge where `sec_tick` is high.
- R4: A `load` pulse copies all seven load inputs into the fields on the next edge and clears the prescaler. The first `sec_tick` after the load is then seen in the 2^PRESC_BITS-th cycle after the load edge.
- R5: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R6: Hours count 00 to 23. At 23 the hours wrap to 00 and carry into both the day of week and the day of month.
- R7: Day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R8: In month 02 the day of month wraps after 29 when the two-digit BCD year is divisible by four (00 counts as leap), and after 28 otherwise.
- R9: Day of week counts 1 to 7. It advances at the same edge as day of month and wraps from 7 to 1.
- R10: Month counts 01 to 12 and wraps to 01, carrying into the year. The year counts 00 to 99 and wraps to 00.
- R11: Every nibble of every field holds a decimal digit (0 to 9) at all times, given valid loaded values.
- R12: When `load` coincides with a `sec_tick`, the loaded values win and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator enable; counting runs only while high |
| load | input | 1 | One-cycle strobe that writes all load fields |
| ld_second | input | 8 | BCD seconds to load |
| ld_minute | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load (24-hour) |
| ld_dow | input | 8 | Day of week to load, 1 to 7 |
| ld_date | input | 8 | BCD day of month to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD two-digit year to load |
| sec_tick | output | 1 | One-per-second enable pulse |
| second | output | 8 | BCD seconds |
| minute | output | 8 | BCD minutes |
| hour | output | 8 | BCD hours |
| dow | output | 8 | Day of week |
| date | output | 8 | BCD day of month |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year |

## Verification
On every cycle, the assertions check the field ranges, the decimal digits, the day of month against the current month's last day, the hold while stopped, the load copy and the lock-step between day of week and day of month. Only the bench scenarios can show that a given rollover lands on the correct next value. Those scenarios cover February in leap years, non-leap years and year 00, the 30- and 31-day month ends, the year-99 wrap, the spacing between seconds after a load, and a load that coincides with a tick.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int BCD_W      = 8;
    localparam int NUM_FIELDS = 7;

    typedef logic [BCD_W-1:0] bcd_t;

    // Field order matters: index 0 is the fastest counter.
    typedef enum int {
        F_SEC   = 0,
        F_MIN   = 1,
        F_HOUR  = 2,
        F_DOW   = 3,
        F_DATE  = 4,
        F_MONTH = 5,
        F_YEAR  = 6
    } field_e;

    typedef struct packed {
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t dow;
        bcd_t hour;
        bcd_t minute;
        bcd_t second;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{
        year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
        hour: 8'h00, minute: 8'h00, second: 8'h00
    };

    function automatic logic bcd_ok(input bcd_t v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < BCD_W / 4; i++) begin
            if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
    parameter int PRESC_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam logic [PRESC_BITS-1:0] TERM = {PRESC_BITS{1'b1}};

    logic [PRESC_BITS-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == TERM);

    // R3: pulses are single-cycle and separated by the full period
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: a clear restarts the count, so no tick follows directly
    p_clear_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tick);
endmodule

// File: rtl/cal_bcd_field.sv
`timescale 1ns/1ps
module cal_bcd_field
    import cal_pkg::*;
(
    input  bcd_t cur,
    input  bcd_t lo,
    input  bcd_t hi,
    input  logic inc,
    output bcd_t nxt,
    output logic wrap
);
    always_comb begin
        nxt  = cur;
        wrap = 1'b0;
        if (inc) begin
            if (cur >= hi) begin
                nxt  = lo;
                wrap = 1'b1;
            end else if (cur[3:0] >= 4'd9) begin
                nxt = {cur[BCD_W-1:4] + 1'b1, 4'h0};
            end else begin
                nxt = {cur[BCD_W-1:4], cur[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/cal_month_len.sv
`timescale 1ns/1ps
module cal_month_len
    import cal_pkg::*;
(
    input  bcd_t month,
    input  bcd_t year,
    output bcd_t last_day,
    output logic leap
);
    // 10*T + U is congruent to 2*T + U modulo 4
    logic [1:0] mod4;

    always_comb begin
        mod4 = {year[4], 1'b0} + year[1:0];
        leap = (mod4 == 2'd0);
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chain.sv
`timescale 1ns/1ps
module rtc_calendar_chain
    import cal_pkg::*;
#(
    parameter int PRESC_BITS = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       load,
    input  logic [7:0] ld_second,
    input  logic [7:0] ld_minute,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    output logic       sec_tick,
    output logic [7:0] second,
    output logic [7:0] minute,
    output logic [7:0] hour,
    output logic [7:0] dow,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year
);
    typedef struct packed {
        cal_time_t t;
    } state_t;

    state_t    st_d, st_q;
    cal_time_t ld_vec;
    bcd_t      month_last;
    logic      leap_yr;

    bcd_t cur_f  [NUM_FIELDS];
    bcd_t nxt_f  [NUM_FIELDS];
    bcd_t lo_f   [NUM_FIELDS];
    bcd_t hi_f   [NUM_FIELDS];
    logic inc_f  [NUM_FIELDS];
    logic wrap_f [NUM_FIELDS];

    cal_prescaler #(.PRESC_BITS(PRESC_BITS)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (osc_en),
        .clear (load),
        .tick  (sec_tick)
    );

    cal_month_len i_mlen (
        .month    (st_q.t.month),
        .year     (st_q.t.year),
        .last_day (month_last),
        .leap     (leap_yr)
    );

    assign ld_vec = '{year: ld_year, month: ld_month, date: ld_date, dow: ld_dow,
                      hour: ld_hour, minute: ld_minute, second: ld_second};

    // Per-field bounds and the carry network
    always_comb begin
        cur_f[F_SEC]   = st_q.t.second;
        cur_f[F_MIN]   = st_q.t.minute;
        cur_f[F_HOUR]  = st_q.t.hour;
        cur_f[F_DOW]   = st_q.t.dow;
        cur_f[F_DATE]  = st_q.t.date;
        cur_f[F_MONTH] = st_q.t.month;
        cur_f[F_YEAR]  = st_q.t.year;

        lo_f[F_SEC]   = 8'h00; hi_f[F_SEC]   = 8'h59;
        lo_f[F_MIN]   = 8'h00; hi_f[F_MIN]   = 8'h59;
        lo_f[F_HOUR]  = 8'h00; hi_f[F_HOUR]  = 8'h23;
        lo_f[F_DOW]   = 8'h01; hi_f[F_DOW]   = 8'h07;
        lo_f[F_DATE]  = 8'h01; hi_f[F_DATE]  = month_last;
        lo_f[F_MONTH] = 8'h01; hi_f[F_MONTH] = 8'h12;
        lo_f[F_YEAR]  = 8'h00; hi_f[F_YEAR]  = 8'h99;

        inc_f[F_SEC]   = sec_tick;
        inc_f[F_MIN]   = wrap_f[F_SEC];
        inc_f[F_HOUR]  = wrap_f[F_MIN];
        inc_f[F_DOW]   = wrap_f[F_HOUR];
        inc_f[F_DATE]  = wrap_f[F_HOUR];
        inc_f[F_MONTH] = wrap_f[F_DATE];
        inc_f[F_YEAR]  = wrap_f[F_MONTH];
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        cal_bcd_field i_fld (
            .cur  (cur_f[g]),
            .lo   (lo_f[g]),
            .hi   (hi_f[g]),
            .inc  (inc_f[g]),
            .nxt  (nxt_f[g]),
            .wrap (wrap_f[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.t = ld_vec;
        end else begin
            st_d.t.second = nxt_f[F_SEC];
            st_d.t.minute = nxt_f[F_MIN];
            st_d.t.hour   = nxt_f[F_HOUR];
            st_d.t.dow    = nxt_f[F_DOW];
            st_d.t.date   = nxt_f[F_DATE];
            st_d.t.month  = nxt_f[F_MONTH];
            st_d.t.year   = nxt_f[F_YEAR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{t: CAL_RESET};
        else        st_q <= st_d;
    end

    assign second = st_q.t.second;
    assign minute = st_q.t.minute;
    assign hour   = st_q.t.hour;
    assign dow    = st_q.t.dow;
    assign date   = st_q.t.date;
    assign month  = st_q.t.month;
    assign year   = st_q.t.year;

    // R2: stopped oscillator freezes the fields
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !load) |=> $stable(st_q));

    // R3: fields move only on a tick (or a load)
    p_move_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !load) |=> $stable(st_q));

    // R4, R12: load copies the inputs and beats a coincident tick
    p_load_copy_r4_r12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.t == $past(ld_vec)));

    // R5
    p_min_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.t.second <= 8'h59) && (st_q.t.minute <= 8'h59));

    // R6
    p_hour_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t.hour <= 8'h23);

    // R7, R8: day never passes the current month's last day
    p_date_in_month_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.t.date >= 8'h01) && (st_q.t.date <= month_last));

    // R9
    p_dow_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.t.dow >= 8'h01) && (st_q.t.dow <= 8'h07));

    p_dow_with_date_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && sec_tick && (st_d.t.date != st_q.t.date))
            |=> (st_q.t.dow != $past(st_q.t.dow)));

    // R10
    p_month_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.t.month >= 8'h01) && (st_q.t.month <= 8'h12));

    // R11
    p_bcd_digits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_ok(st_q.t.second) && bcd_ok(st_q.t.minute) && bcd_ok(st_q.t.hour) &&
        bcd_ok(st_q.t.dow) && bcd_ok(st_q.t.date) && bcd_ok(st_q.t.month) &&
        bcd_ok(st_q.t.year));
endmodule

// File: tb/test_rtc_calendar_chain.sv
`timescale 1ns/1ps
module test_rtc_calendar_chain;
    localparam int PB      = 4;
    localparam int SEC_CYC = 1 << PB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] ld_second = '0, ld_minute = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0;
    logic       sec_tick;
    logic [7:0] second, minute, hour, dow, date, month, year;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_calendar_chain #(.PRESC_BITS(PB)) i_rtc_calendar_chain (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .load(load),
        .ld_second(ld_second), .ld_minute(ld_minute), .ld_hour(ld_hour),
        .ld_dow(ld_dow), .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .sec_tick(sec_tick), .second(second), .minute(minute), .hour(hour),
        .dow(dow), .date(date), .month(month), .year(year)
    );

    // {year, month, date, dow, hour, minute, second}
    function automatic logic [55:0] tv(input logic [7:0] y, mo, d, w, h, mi, s);
        return {y, mo, d, w, h, mi, s};
    endfunction

    function automatic logic [55:0] now();
        return {year, month, date, dow, hour, minute, second};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_digits(input string req);
        logic [55:0] v;
        logic ok;
        v  = now();
        ok = 1'b1;
        for (int i = 0; i < 14; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
        chk(req, {63'd0, ok}, 64'd1);
    endtask

    task automatic do_load(input logic [55:0] v);
        @(negedge clk);
        {ld_year, ld_month, ld_date, ld_dow, ld_hour, ld_minute, ld_second} = v;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Counts negedges from the one after the load edge until sec_tick is seen.
    task automatic wait_tick(output int n);
        n = 1;
        while (!sec_tick && n < 4 * SEC_CYC) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic roll(input string req, input logic [55:0] from, input logic [55:0] exp);
        int n;
        osc_en = 1'b1;
        do_load(from);
        chk({req, " loaded"}, {8'd0, now()}, {8'd0, from});
        wait_tick(n);
        chk("R4 first tick spacing", n, SEC_CYC);
        @(negedge clk);
        chk(req, {8'd0, now()}, {8'd0, exp});
        chk_digits("R11 digits");
    endtask

    task automatic t_reset();
        chk("R1 reset fields", {8'd0, now()},
            {8'd0, tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00)});
        chk("R1 reset tick", {63'd0, sec_tick}, 64'd0);
    endtask

    task automatic t_stopped();
        logic [55:0] v;
        bit seen;
        v = tv(8'h24, 8'h03, 8'h15, 8'h05, 8'h10, 8'h20, 8'h30);
        osc_en = 1'b0;
        do_load(v);
        seen = 1'b0;
        for (int i = 0; i < 4 * SEC_CYC; i++) begin
            @(negedge clk);
            if (sec_tick) seen = 1'b1;
        end
        chk("R2 held while stopped", {8'd0, now()}, {8'd0, v});
        chk("R2 no tick while stopped", {63'd0, seen}, 64'd0);
    endtask

    task automatic t_period();
        int n;
        osc_en = 1'b1;
        do_load(tv(8'h24, 8'h03, 8'h15, 8'h05, 8'h10, 8'h20, 8'h30));
        wait_tick(n);
        @(negedge clk);
        n = 1;
        while (!sec_tick && n < 4 * SEC_CYC) begin
            @(negedge clk);
            n++;
        end
        chk("R3 tick period", n, SEC_CYC);
        @(negedge clk);
        chk("R3 two seconds elapsed", second, 8'h32);
    endtask

    task automatic t_load_wins();
        int n;
        logic [55:0] v;
        v = tv(8'h30, 8'h07, 8'h04, 8'h02, 8'h08, 8'h00, 8'h00);
        osc_en = 1'b1;
        wait_tick(n);
        {ld_year, ld_month, ld_date, ld_dow, ld_hour, ld_minute, ld_second} = v;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R12 load beats tick", {8'd0, now()}, {8'd0, v});
        wait_tick(n);
        chk("R12 prescaler restarted", n, SEC_CYC);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_period();
        roll("R5 seconds carry into minutes",
             tv(8'h23, 8'h06, 8'h10, 8'h06, 8'h12, 8'h34, 8'h59),
             tv(8'h23, 8'h06, 8'h10, 8'h06, 8'h12, 8'h35, 8'h00));
        roll("R5 minutes carry into hours",
             tv(8'h23, 8'h06, 8'h10, 8'h06, 8'h09, 8'h59, 8'h59),
             tv(8'h23, 8'h06, 8'h10, 8'h06, 8'h10, 8'h00, 8'h00));
        roll("R6 R7 31-day month end",
             tv(8'h23, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59),
             tv(8'h23, 8'h02, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
        roll("R7 day 30 of 31-day month",
             tv(8'h23, 8'h08, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59),
             tv(8'h23, 8'h08, 8'h31, 8'h04, 8'h00, 8'h00, 8'h00));
        roll("R7 30-day month April",
             tv(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
             tv(8'h23, 8'h05, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R7 30-day month November",
             tv(8'h23, 8'h11, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59),
             tv(8'h23, 8'h12, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
        roll("R8 Feb 28 non-leap 23",
             tv(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
             tv(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
        roll("R8 Feb 28 non-leap 10",
             tv(8'h10, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59),
             tv(8'h10, 8'h03, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        roll("R8 Feb 28 leap 24",
             tv(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59),
             tv(8'h24, 8'h02, 8'h29, 8'h04, 8'h00, 8'h00, 8'h00));
        roll("R8 Feb 29 leap 12",
             tv(8'h12, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59),
             tv(8'h12, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
        roll("R8 Feb 28 leap year 00",
             tv(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59),
             tv(8'h00, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00));
        roll("R9 R10 Dec 31 year 99 wrap",
             tv(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59),
             tv(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        roll("R10 Dec 31 year carry",
             tv(8'h23, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59),
             tv(8'h24, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00));
        roll("R10 month digit carry 09 to 10",
             tv(8'h19, 8'h09, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59),
             tv(8'h19, 8'h10, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
        t_load_wins();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule